// File: doc/BRIEF.md
# Dual-Slot Early Branch Target Resolver

This block sits at the front of a two-wide in-order fetch path and finds branch targets for both fetched instructions in the same cycle. Each slot has its own partial decoder that recognises three branch kinds (direct jump, conditional branch, register-indirect jump) and its own shortened adder for PC-relative targets. Register-indirect targets come from one bank of three 32-bit target buffers that both slots read.

The bank is kept up to date through a single write port. When the instruction buffer is being refilled, the block cannot trust what it sees. Every instruction presented during the refill window is therefore reported as unhandled, so that a separate reduced target buffer can cover it. All per-slot results are registered and appear one cycle after the slot is presented.

Top module: `ebt_dual`

## Requirements
- R1: Each slot is decoded on its own every cycle. `slot_br_o`, `slot_kind_o`, `slot_tgt_o` and `slot_hdl_o` for slot s reflect the inputs of slot s from the previous clock edge. When `slot_vld_i[s]` was low, all four are zero.
- R2: An instruction is a branch only when inst[1:0] equals CLS_PAT (default 2'b11). Its kind then comes from inst[7:2]: OP_JMP (6'h01) sets kind bit 0, OP_BR (6'h02) sets bit 1, and OP_IND (6'h03) sets bit 2. The kind is one-hot for a branch and zero otherwise.
- R3: For a direct jump or a conditional branch, take inst[31:14] as an 18-bit signed offset in words. Let sum = (pc[21:0] + offset*4) mod 2^22. The target is {pc[31:22], sum[21:2], 2'b00}.
- R4: For an indirect jump, the target is target buffer number inst[9:8] when that index is 0, 1 or 2. Index 3 gives target 0 and is never handled.
- R5: The target buffers reset to zero. A write with `rb_wr_en_i` high and index 3 changes none of them.
- R6: A write and an indirect read of the same buffer in the same cycle return the newly written data.
- R7: A slot presented in a cycle with `refill_req_i` high, or in any of the LAT (default 2) cycles after that request, is unhandled. A new request restarts the window.
- R8: `slot_hdl_o` is high exactly when the slot held a branch with a usable target outside a refill window. A non-branch gives target 0 and handled 0.
- R9: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | 2 | Slot holds a fetched instruction |
| slot_pc_i | input | 2x32 | PC of each slot |
| slot_inst_i | input | 2x32 | Instruction word of each slot |
| rb_wr_en_i | input | 1 | Target buffer write enable |
| rb_wr_idx_i | input | 2 | Target buffer write index |
| rb_wr_data_i | input | 32 | Target buffer write data |
| refill_req_i | input | 1 | Instruction buffer refill starts |
| slot_br_o | output | 2 | Slot held a branch |
| slot_kind_o | output | 2x3 | One-hot branch kind per slot |
| slot_tgt_o | output | 2x32 | Resolved target per slot |
| slot_hdl_o | output | 2 | Target resolved by this block |

## Verification
The assertions assume that the three opcode parameters are distinct, which is what makes the kind one-hot. They also assume that reset is held long enough for the refill counter to clear. The stimulus keeps the default patterns. Beyond those, it builds instructions only from well-formed fields: any class value, any of the three branch opcodes or a non-branch opcode, every buffer index including 3, and the full signed offset range. Refill requests arrive both isolated and back to back, so that the window restart is reached.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  localparam int NSLOT   = 2;
  localparam int XLEN    = 32;
  localparam int NREG    = 3;
  localparam int IDX_W   = 2;
  localparam int NKIND   = 3;
  localparam int ADD_W   = 22;
  localparam int IMM_W   = 18;
  localparam int CLS_LSB = 0;
  localparam int OP_LSB  = 2;
  localparam int IDX_LSB = 8;
  localparam int IMM_LSB = 14;

  localparam int K_JMP = 0;
  localparam int K_BR  = 1;
  localparam int K_IND = 2;

  typedef logic [NKIND-1:0] kind_t;
endpackage

// File: rtl/ebt_pdec.sv
module ebt_pdec
  import ebt_pkg::*;
#(
  parameter logic [1:0] CLS_PAT = 2'b11,
  parameter logic [5:0] OP_JMP  = 6'h01,
  parameter logic [5:0] OP_BR   = 6'h02,
  parameter logic [5:0] OP_IND  = 6'h03
) (
  input  logic [XLEN-1:0]  inst_i,
  output kind_t            kind_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IMM_W-1:0] imm_o
);
  logic       cls_hit;
  logic [5:0] op;

  // four parallel AND terms: class term gates the three opcode terms
  assign cls_hit       = (inst_i[CLS_LSB +: 2] == CLS_PAT);
  assign op            = inst_i[OP_LSB +: 6];
  assign kind_o[K_JMP] = cls_hit & (op == OP_JMP);
  assign kind_o[K_BR]  = cls_hit & (op == OP_BR);
  assign kind_o[K_IND] = cls_hit & (op == OP_IND);
  assign idx_o         = inst_i[IDX_LSB +: IDX_W];
  assign imm_o         = inst_i[IMM_LSB +: IMM_W];
endmodule

// File: rtl/ebt_tgt_add.sv
module ebt_tgt_add
  import ebt_pkg::*;
(
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int EXT = ADD_W - IMM_W - 2;

  logic [ADD_W-1:0] off;
  logic [ADD_W-1:0] sum;

  // short adder over the low PC bits only
  assign off   = {{EXT{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign sum   = pc_i[ADD_W-1:0] + off;
  assign tgt_o = {pc_i[XLEN-1:ADD_W], sum[ADD_W-1:2], 2'b00};
endmodule

// File: rtl/ebt_regbuf.sv
module ebt_regbuf
  import ebt_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [XLEN-1:0]             wr_data_i,
  input  logic [NSLOT-1:0][IDX_W-1:0] rd_idx_i,
  output logic [NSLOT-1:0][XLEN-1:0]  rd_data_o,
  output logic [NSLOT-1:0]            rd_ok_o
);
  logic [NREG-1:0][XLEN-1:0] regs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en_i && (wr_idx_i == IDX_W'(r))) regs[r] <= wr_data_i;
      end
    end
  end

  // one storage copy, one read port per slot, write bypass
  for (genvar s = 0; s < NSLOT; s++) begin : g_rd
    always_comb begin
      rd_data_o[s] = '0;
      rd_ok_o[s]   = 1'b0;
      for (int r = 0; r < NREG; r++) begin
        if (rd_idx_i[s] == IDX_W'(r)) begin
          rd_ok_o[s]   = 1'b1;
          rd_data_o[s] = (wr_en_i && (wr_idx_i == IDX_W'(r))) ? wr_data_i : regs[r];
        end
      end
    end
  end
endmodule

// File: rtl/ebt_refill.sv
module ebt_refill #(
  parameter int LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt <= '0;
    else if (req_i)      cnt <= CW'(LAT);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy_o = req_i | (cnt != '0);
endmodule

// File: rtl/ebt_dual.sv
module ebt_dual
  import ebt_pkg::*;
#(
  parameter int         LAT     = 2,
  parameter logic [1:0] CLS_PAT = 2'b11,
  parameter logic [5:0] OP_JMP  = 6'h01,
  parameter logic [5:0] OP_BR   = 6'h02,
  parameter logic [5:0] OP_IND  = 6'h03
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSLOT-1:0]           slot_vld_i,
  input  logic [NSLOT-1:0][XLEN-1:0] slot_pc_i,
  input  logic [NSLOT-1:0][XLEN-1:0] slot_inst_i,
  input  logic                       rb_wr_en_i,
  input  logic [IDX_W-1:0]           rb_wr_idx_i,
  input  logic [XLEN-1:0]            rb_wr_data_i,
  input  logic                       refill_req_i,
  output logic [NSLOT-1:0]           slot_br_o,
  output logic [NSLOT-1:0][NKIND-1:0] slot_kind_o,
  output logic [NSLOT-1:0][XLEN-1:0] slot_tgt_o,
  output logic [NSLOT-1:0]           slot_hdl_o
);
  logic                        busy;
  logic [NSLOT-1:0][IDX_W-1:0] rd_idx;
  logic [NSLOT-1:0][XLEN-1:0]  rd_data;
  logic [NSLOT-1:0]            rd_ok;

  ebt_refill #(.LAT(LAT)) i_refill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (refill_req_i),
    .busy_o (busy)
  );

  ebt_regbuf i_regbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (rb_wr_en_i),
    .wr_idx_i  (rb_wr_idx_i),
    .wr_data_i (rb_wr_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .rd_ok_o   (rd_ok)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    kind_t            kind;
    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  rel_tgt;
    logic             br_d;
    logic             hdl_d;
    logic [XLEN-1:0]  tgt_d;

    ebt_pdec #(
      .CLS_PAT (CLS_PAT),
      .OP_JMP  (OP_JMP),
      .OP_BR   (OP_BR),
      .OP_IND  (OP_IND)
    ) i_pdec (
      .inst_i (slot_inst_i[s]),
      .kind_o (kind),
      .idx_o  (rd_idx[s]),
      .imm_o  (imm)
    );

    ebt_tgt_add i_add (
      .pc_i  (slot_pc_i[s]),
      .imm_i (imm),
      .tgt_o (rel_tgt)
    );

    always_comb begin
      br_d  = slot_vld_i[s] & (kind != '0);
      tgt_d = '0;
      hdl_d = 1'b0;
      if (br_d) begin
        if (kind[K_IND]) begin
          tgt_d = rd_data[s];
          hdl_d = rd_ok[s] & ~busy;
        end else begin
          tgt_d = rel_tgt;
          hdl_d = ~busy;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_br_o[s]   <= 1'b0;
        slot_kind_o[s] <= '0;
        slot_tgt_o[s]  <= '0;
        slot_hdl_o[s]  <= 1'b0;
      end else begin
        slot_br_o[s]   <= br_d;
        slot_kind_o[s] <= br_d ? kind : '0;
        slot_tgt_o[s]  <= tgt_d;
        slot_hdl_o[s]  <= hdl_d;
      end
    end
  end
endmodule

// File: rtl/ebt_dual_chk.sv
module ebt_dual_chk
  import ebt_pkg::*;
#(
  parameter int LAT = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NSLOT-1:0]            slot_vld_i,
  input logic [NSLOT-1:0][XLEN-1:0]  slot_pc_i,
  input logic                        refill_req_i,
  input logic [NSLOT-1:0]            slot_br_o,
  input logic [NSLOT-1:0][NKIND-1:0] slot_kind_o,
  input logic [NSLOT-1:0][XLEN-1:0]  slot_tgt_o,
  input logic [NSLOT-1:0]            slot_hdl_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    assert_kind_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(slot_kind_o[s]));

    assert_idle_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_vld_i[s] |=> (!slot_br_o[s] && !slot_hdl_o[s] && slot_tgt_o[s] == '0));

    assert_hdl_needs_br_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_hdl_o[s] |-> slot_br_o[s]);

    assert_refill_unhandled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      refill_req_i |=> !slot_hdl_o[s]);

    assert_rel_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_br_o[s] && !slot_kind_o[s][K_IND]) |->
        (slot_tgt_o[s][XLEN-1:ADD_W] == $past(slot_pc_i[s][XLEN-1:ADD_W])
         && slot_tgt_o[s][1:0] == 2'b00));
  end
endmodule

bind ebt_dual ebt_dual_chk #(.LAT(LAT)) i_ebt_dual_chk (.*);

// File: tb/test_ebt_dual.sv
module test_ebt_dual;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        slot_vld_i = '0;
  logic [1:0][31:0]  slot_pc_i = '0;
  logic [1:0][31:0]  slot_inst_i = '0;
  logic              rb_wr_en_i = 1'b0;
  logic [1:0]        rb_wr_idx_i = '0;
  logic [31:0]       rb_wr_data_i = '0;
  logic              refill_req_i = 1'b0;
  logic [1:0]        slot_br_o;
  logic [1:0][2:0]   slot_kind_o;
  logic [1:0][31:0]  slot_tgt_o;
  logic [1:0]        slot_hdl_o;

  ebt_dual #(.LAT(LAT)) i_ebt_dual (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] mreg [3];
  int          mcnt;
  bit          have_exp;
  logic        e_br   [2];
  logic [2:0]  e_kind [2];
  logic [31:0] e_tgt  [2];
  logic        e_hdl  [2];
  string       t_tgt  [2];
  string       t_hdl  [2];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (!have_exp) return;
    for (int s = 0; s < 2; s++) begin
      chk("R1", $sformatf("slot%0d br", s), 32'(slot_br_o[s]), 32'(e_br[s]));
      chk("R2", $sformatf("slot%0d kind", s), 32'(slot_kind_o[s]), 32'(e_kind[s]));
      chk(t_tgt[s], $sformatf("slot%0d target", s), slot_tgt_o[s], e_tgt[s]);
      chk(t_hdl[s], $sformatf("slot%0d handled", s), 32'(slot_hdl_o[s]), 32'(e_hdl[s]));
    end
  endtask

  task automatic step(input logic [1:0] vld, input logic [31:0] i0, input logic [31:0] i1,
                      input logic [31:0] p0, input logic [31:0] p1,
                      input logic we, input logic [1:0] wi, input logic [31:0] wd,
                      input logic rq);
    logic [31:0] ins [2];
    logic [31:0] pcs [2];
    bit busy;
    @(negedge clk_i);
    compare();
    slot_vld_i = vld; slot_inst_i[0] = i0; slot_inst_i[1] = i1;
    slot_pc_i[0] = p0; slot_pc_i[1] = p1;
    rb_wr_en_i = we; rb_wr_idx_i = wi; rb_wr_data_i = wd; refill_req_i = rq;
    ins[0] = i0; ins[1] = i1; pcs[0] = p0; pcs[1] = p1;
    busy = rq || (mcnt > 0);
    for (int s = 0; s < 2; s++) begin
      int k;
      k = -1;
      if (ins[s][1:0] == 2'b11) begin
        if (ins[s][7:2] == 6'h01) k = 0;
        else if (ins[s][7:2] == 6'h02) k = 1;
        else if (ins[s][7:2] == 6'h03) k = 2;
      end
      e_br[s] = 0; e_kind[s] = 0; e_tgt[s] = 0; e_hdl[s] = 0;
      t_hdl[s] = busy ? "R7" : "R8";
      t_tgt[s] = "R8";
      if (vld[s] && k >= 0) begin
        e_br[s] = 1;
        e_kind[s] = 3'(1 << k);
        if (k < 2) begin
          longint off, sum;
          off = longint'($signed(ins[s][31:14])) * 4;
          sum = (longint'(pcs[s][21:0]) + off) & 64'h3FFFFF;
          e_tgt[s] = {pcs[s][31:22], 22'(sum & 64'h3FFFFC)};
          e_hdl[s] = !busy;
          t_tgt[s] = "R3";
        end else begin
          int ix;
          ix = int'(ins[s][9:8]);
          t_tgt[s] = "R4";
          if (ix < 3) begin
            if (we && wi == 2'(ix)) begin
              e_tgt[s] = wd; t_tgt[s] = "R6";
            end else begin
              e_tgt[s] = mreg[ix];
              if (we && wi == 2'd3) t_tgt[s] = "R5";
            end
            e_hdl[s] = !busy;
          end
        end
      end
    end
    have_exp = 1;
    if (we && wi != 2'd3) mreg[int'(wi)] = wd;
    mcnt = rq ? LAT : (mcnt > 0 ? mcnt - 1 : 0);
  endtask

  function automatic logic [31:0] mk(input int k, input logic [17:0] imm, input logic [1:0] ix);
    logic [5:0] op;
    op = (k == 0) ? 6'h01 : (k == 1) ? 6'h02 : (k == 2) ? 6'h03 : 6'h2A;
    return {imm, 4'h5, ix, op, 2'b11};
  endfunction

  task automatic idle();
    step(2'b00, '0, '0, '0, '0, 1'b0, 2'd0, '0, 1'b0);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 3; r++) mreg[r] = '0;
    mcnt = 0; have_exp = 0;
    slot_vld_i = 2'b11;
    slot_inst_i[0] = mk(0, 18'h1, 2'd0);
    slot_inst_i[1] = mk(2, 18'h0, 2'd0);
    repeat (3) @(negedge clk_i);
    // R9: outputs held at zero during reset
    chk("R9", "br", 32'(slot_br_o), 0);
    chk("R9", "kind", 32'(slot_kind_o), 0);
    chk("R9", "target", slot_tgt_o[0] | slot_tgt_o[1], 0);
    chk("R9", "handled", 32'(slot_hdl_o), 0);
    slot_vld_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5: buffers read as zero after reset
    step(2'b11, mk(2, '0, 2'd0), mk(2, '0, 2'd2), 32'h100, 32'h104, 1'b0, 2'd0, '0, 1'b0);
    // fill buffers
    step(2'b00, '0, '0, '0, '0, 1'b1, 2'd0, 32'hAAAA_0000, 1'b0);
    step(2'b00, '0, '0, '0, '0, 1'b1, 2'd1, 32'hBBBB_0004, 1'b0);
    step(2'b00, '0, '0, '0, '0, 1'b1, 2'd2, 32'hCCCC_0008, 1'b0);
    // R4: indirect reads, index 3 unhandled
    step(2'b11, mk(2, '0, 2'd0), mk(2, '0, 2'd1), 32'h200, 32'h204, 1'b0, 2'd0, '0, 1'b0);
    step(2'b11, mk(2, '0, 2'd2), mk(2, '0, 2'd3), 32'h208, 32'h20C, 1'b0, 2'd0, '0, 1'b0);
    // R6: bypass on same-cycle write
    step(2'b11, mk(2, '0, 2'd2), mk(2, '0, 2'd2), 32'h210, 32'h214, 1'b1, 2'd2, 32'hDDDD_000C, 1'b0);
    // R5: write to index 3 changes nothing
    step(2'b11, mk(2, '0, 2'd0), mk(2, '0, 2'd1), 32'h218, 32'h21C, 1'b1, 2'd3, 32'hEEEE_EEEE, 1'b0);
    step(2'b11, mk(2, '0, 2'd2), mk(2, '0, 2'd0), 32'h220, 32'h224, 1'b0, 2'd0, '0, 1'b0);
    // R3: positive, negative and wrapping offsets
    step(2'b11, mk(0, 18'h00010, 2'd0), mk(1, 18'h3FFFF, 2'd0), 32'h1234_5678, 32'h1234_567C, 1'b0, 2'd0, '0, 1'b0);
    step(2'b11, mk(1, 18'h20000, 2'd0), mk(0, 18'h1FFFF, 2'd0), 32'hFFC0_0000, 32'h003F_FFFC, 1'b0, 2'd0, '0, 1'b0);
    // R2: wrong class or opcode is not a branch
    step(2'b11, {mk(0, 18'h5, 2'd0)} & 32'hFFFF_FFFE, mk(3, 18'h5, 2'd0), 32'h40, 32'h44, 1'b0, 2'd0, '0, 1'b0);
    // R1: invalid slot suppressed
    step(2'b01, mk(0, 18'h5, 2'd0), mk(1, 18'h5, 2'd0), 32'h40, 32'h44, 1'b0, 2'd0, '0, 1'b0);
    // R7: refill window, then restart
    step(2'b11, mk(0, 18'h8, 2'd0), mk(2, '0, 2'd0), 32'h300, 32'h304, 1'b0, 2'd0, '0, 1'b1);
    for (int c = 0; c < LAT + 2; c++)
      step(2'b11, mk(1, 18'h8, 2'd0), mk(0, 18'h3FFF0, 2'd0), 32'h308, 32'h30C, 1'b0, 2'd0, '0, 1'b0);
    step(2'b11, mk(0, 18'h8, 2'd0), mk(0, 18'h8, 2'd0), 32'h400, 32'h404, 1'b0, 2'd0, '0, 1'b1);
    step(2'b11, mk(0, 18'h8, 2'd0), mk(0, 18'h8, 2'd0), 32'h408, 32'h40C, 1'b0, 2'd0, '0, 1'b0);
    step(2'b11, mk(0, 18'h8, 2'd0), mk(0, 18'h8, 2'd0), 32'h410, 32'h414, 1'b0, 2'd0, '0, 1'b1);
    for (int c = 0; c < LAT + 2; c++)
      step(2'b11, mk(2, '0, 2'd1), mk(1, 18'h1, 2'd0), 32'h418, 32'h41C, 1'b0, 2'd0, '0, 1'b0);

    // mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] i0, i1;
      i0 = mk(int'($urandom_range(0, 3)), 18'($urandom), 2'($urandom));
      i1 = mk(int'($urandom_range(0, 3)), 18'($urandom), 2'($urandom));
      if ($urandom_range(0, 9) == 0) i0[1:0] = 2'($urandom);
      step(2'($urandom), i0, i1, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
           1'($urandom_range(0, 2) == 0), 2'($urandom), $urandom,
           1'($urandom_range(0, 19) == 0));
    end
    idle();
    idle();
    finish_run();
  end
endmodule